// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a 16-bit host bus reach internal registers that are wider than the bus. The host sees six registers: a status word, an address word and four data words. To write a wide register, the host first loads the data words. It then writes the address word, and that write alone starts the transfer. To read a wide register, the host issues one address write per 16-bit slice. Each of those writes carries a slice index, and the selected slice arrives in data word 0 once the transfer ends.

A transfer holds the busy flag for a fixed number of clock cycles. During that time further address writes are dropped. The internal file holds four registers:
- a 5-bit port-enable register;
- a 5-bit byte-order register;
- a 32-bit codec control register;
- a 64-bit timer load register.

Every internal register drives an output pin. The status word also carries two host-writable active-low reset outputs.

Top module: `ind_reg_bridge`

## Requirements
- R1: After reset, every host-visible register reads 0 and every output is 0, so both reset outputs are asserted.
- R2: A host write to the address word (select 1) while idle sets status bit 0 (busy) from the next cycle for exactly BUSY_CYCLES cycles.
- R3: An address write that arrives while busy is ignored: it neither restarts the timing nor changes the target or the address word.
- R4: A write transfer to address 0x9104 loads data word 0 bits 4:0 into the port-enable register. A write transfer to 0x9108 loads them into the byte-order register, where 1 means little-endian. Bit i of each register belongs to one port, in the order synth input, digital audio receive, digital audio transmit, codec transmit, codec receive (bit 0 first).
- R5: A write transfer to 0x1408 loads the codec control register with data word 1 in bits 31:16 and data word 0 in bits 15:0.
- R6: A write transfer to 0x3104 loads the 64-bit timer register from data words 3, 2, 1 and 0, with word 3 most significant.
- R7: An address with bit 7 set is a read. When busy clears, data word 0 holds the 16-bit slice that address bits 1:0 select (slice k is bits 16k+15:16k) of the register addressed by bits 15:12 (type), 11:8 (instance) and 3:2 (parameter).
- R8: A read slice that lies above a register's width returns 0.
- R9: An address that decodes to no internal register changes nothing on a write and returns 0 on a read.
- R10: Status bits 3 and 4 are host-writable and drive the chip-reset and codec-reset outputs. A write to status bit 0 has no effect.
- R11: Data words (selects 2 to 5) and the address word read back the last value written to them.
- R12: Internal registers and their outputs change only on the cycle that a transfer ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 3 | Host register select: 0 status, 1 address, 2..5 data words 0..3 |
| bus_we | input | 1 | Host write strobe |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Host read data for the selected register |
| chip_rst_n | output | 1 | Active-low global reset, from status bit 3 |
| codec_rst_n | output | 1 | Active-low codec reset, from status bit 4 |
| port_enable | output | 5 | Port-enable register |
| little_endian | output | 5 | Byte-order register, 1 = little-endian |
| codec_ctrl | output | 32 | Codec control register |
| timer_value | output | 64 | Timer load register |

## Verification
The bench builds the block with BUSY_CYCLES at its default of 4. This keeps the whole busy window short enough to step through edge by edge. It also makes it possible to place a second address write at a chosen point inside that window. With this setting, random wide writes and random slice reads cover every slice index against every mapped register, including slices above the width of the 5-bit and 32-bit registers.

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge #(
  parameter int BUSY_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  bus_sel,
  input  logic        bus_we,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        chip_rst_n,
  output logic        codec_rst_n,
  output logic [4:0]  port_enable,
  output logic [4:0]  little_endian,
  output logic [31:0] codec_ctrl,
  output logic [63:0] timer_value
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic [CW-1:0] cnt;
  logic [15:0]   addr_q;
  logic [15:0]   dw [4];
  logic          busy, start, done;
  logic          hit_pe, hit_le, hit_cc, hit_tm;
  logic [63:0]   tgt;
  logic [15:0]   slice;

  assign busy  = cnt != '0;
  assign start = bus_we && bus_sel == 3'd1 && !busy;
  assign done  = cnt == CW'(1);

  assign hit_pe = addr_q[15:8] == 8'h91 && addr_q[3:2] == 2'd1;
  assign hit_le = addr_q[15:8] == 8'h91 && addr_q[3:2] == 2'd2;
  assign hit_cc = addr_q[15:8] == 8'h14 && addr_q[3:2] == 2'd2;
  assign hit_tm = addr_q[15:8] == 8'h31 && addr_q[3:2] == 2'd1;

  always_comb begin
    tgt = '0;
    if (hit_pe) tgt = {59'd0, port_enable};
    else if (hit_le) tgt = {59'd0, little_endian};
    else if (hit_cc) tgt = {32'd0, codec_ctrl};
    else if (hit_tm) tgt = timer_value;
  end

  assign slice = tgt[addr_q[1:0]*16 +: 16];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt         <= '0;
      addr_q      <= '0;
      chip_rst_n  <= 1'b0;
      codec_rst_n <= 1'b0;
      port_enable <= '0;
      little_endian <= '0;
      codec_ctrl  <= '0;
      timer_value <= '0;
      for (int i = 0; i < 4; i++) dw[i] <= '0;
    end else begin
      if (start) begin
        addr_q <= bus_wdata;
        cnt    <= CW'(BUSY_CYCLES);
      end else if (busy) begin
        cnt <= cnt - CW'(1);
      end

      if (bus_we && bus_sel == 3'd0) begin
        chip_rst_n  <= bus_wdata[3];
        codec_rst_n <= bus_wdata[4];
      end

      for (int i = 0; i < 4; i++)
        if (bus_we && bus_sel == 3'(i + 2)) dw[i] <= bus_wdata;

      if (done && addr_q[7]) dw[0] <= slice;

      if (done && !addr_q[7]) begin
        if (hit_pe) port_enable   <= dw[0][4:0];
        if (hit_le) little_endian <= dw[0][4:0];
        if (hit_cc) codec_ctrl    <= {dw[1], dw[0]};
        if (hit_tm) timer_value   <= {dw[3], dw[2], dw[1], dw[0]};
      end
    end
  end

  always_comb begin
    case (bus_sel)
      3'd0:    bus_rdata = {11'd0, codec_rst_n, chip_rst_n, 2'd0, busy};
      3'd1:    bus_rdata = addr_q;
      3'd2:    bus_rdata = dw[0];
      3'd3:    bus_rdata = dw[1];
      3'd4:    bus_rdata = dw[2];
      3'd5:    bus_rdata = dw[3];
      default: bus_rdata = '0;
    endcase
  end
endmodule

module ind_reg_bridge_chk #(
  parameter int BUSY_CYCLES = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  bus_sel,
  input logic        bus_we,
  input logic [15:0] bus_wdata,
  input logic        busy,
  input logic [15:0] addr_q,
  input logic        chip_rst_n,
  input logic [4:0]  port_enable,
  input logic [4:0]  little_endian,
  input logic [31:0] codec_ctrl,
  input logic [63:0] timer_value
);
  int unsigned bcnt;
  always_ff @(posedge clk)
    if (!rst_n || !busy) bcnt <= 0;
    else bcnt <= bcnt + 1;

  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && bus_we && bus_sel == 3'd1) |=> busy); // R2
  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> bcnt == BUSY_CYCLES); // R2
  AST_BUSY_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt <= BUSY_CYCLES); // R3
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_we && bus_sel == 3'd1) |=> $stable(addr_q)); // R3
  AST_REGS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy) |-> ($stable(port_enable) && $stable(little_endian) &&
                      $stable(codec_ctrl) && $stable(timer_value))); // R12
  AST_CHIP_RST: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_sel == 3'd0) |=> chip_rst_n == $past(bus_wdata[3])); // R10
endmodule

bind ind_reg_bridge ind_reg_bridge_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (.*);

// File: tb/sim_ind_reg_bridge.sv
`timescale 1ns/1ps
module sim_ind_reg_bridge;
  localparam int BUSY = 4;

  logic        clk = 0, rst_n = 0, bus_we = 0;
  logic [2:0]  bus_sel = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic        chip_rst_n, codec_rst_n;
  logic [4:0]  port_enable, little_endian;
  logic [31:0] codec_ctrl;
  logic [63:0] timer_value;

  int checks = 0, errors = 0;
  logic [4:0]  m_pe = 0, m_le = 0;
  logic [31:0] m_cc = 0;
  logic [63:0] m_tm = 0;

  ind_reg_bridge #(.BUSY_CYCLES(BUSY)) u0 (.*);

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk);
    bus_sel = s; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [15:0] d);
    bus_sel = s;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic access(input logic [15:0] a);
    wr(3'd1, a);
    repeat (BUSY) @(negedge clk);
  endtask

  function automatic logic [63:0] model_reg(input logic [15:0] a);
    if (a[15:8] == 8'h91 && a[3:2] == 2'd1) return {59'd0, m_pe};
    if (a[15:8] == 8'h91 && a[3:2] == 2'd2) return {59'd0, m_le};
    if (a[15:8] == 8'h14 && a[3:2] == 2'd2) return {32'd0, m_cc};
    if (a[15:8] == 8'h31 && a[3:2] == 2'd1) return m_tm;
    return 64'd0;
  endfunction

  task automatic check_outs(input string req);
    chk(port_enable == m_pe, req, port_enable, m_pe);
    chk(little_endian == m_le, req, little_endian, m_le);
    chk(codec_ctrl == m_cc, req, codec_ctrl, m_cc);
    chk(timer_value == m_tm, req, timer_value, m_tm);
  endtask

  task automatic read_slice(input logic [15:0] a, input string req);
    logic [15:0] v;
    logic [63:0] e;
    e = model_reg(a);
    access(a | 16'h0080);
    rd(3'd2, v);
    chk(v == e[a[1:0]*16 +: 16], req, v, e[a[1:0]*16 +: 16]);
  endtask

  initial begin
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [15:0] w [4];
    logic [15:0] base [5];
    void'($urandom(32'd7781));
    base[0] = 16'h9104; base[1] = 16'h9108; base[2] = 16'h1408;
    base[3] = 16'h3104; base[4] = 16'h5104;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int s = 0; s < 6; s++) begin
      rd(3'(s), v);
      chk(v == 16'd0, "R1 reg", v, 0);
    end
    chk({chip_rst_n, codec_rst_n} == 2'b00, "R1 rst", {chip_rst_n, codec_rst_n}, 0);
    check_outs("R1 outs");

    // R10: status bits
    wr(3'd0, 16'h0019);
    rd(3'd0, v);
    chk(v == 16'h0018, "R10 status", v, 16'h0018);
    chk(chip_rst_n && codec_rst_n, "R10 pins", {chip_rst_n, codec_rst_n}, 2'b11);
    wr(3'd0, 16'h0010);
    chk(!chip_rst_n && codec_rst_n, "R10 pins2", {chip_rst_n, codec_rst_n}, 2'b01);

    // R11: data and address words read back
    for (int s = 2; s < 6; s++) begin
      wr(3'(s), 16'h1111 * 16'(s));
      rd(3'(s), v);
      chk(v == 16'h1111 * 16'(s), "R11 data", v, 16'h1111 * 16'(s));
    end

    // R2 busy profile
    wr(3'd2, 16'h0015);
    wr(3'd1, 16'h9104);
    for (int k = 0; k < BUSY; k++) begin
      rd(3'd0, v);
      chk(v[0] == 1'b1, "R2 busy high", v[0], 1);
      chk(port_enable == m_pe, "R12 held", port_enable, m_pe);
      @(negedge clk);
    end
    rd(3'd0, v);
    chk(v[0] == 1'b0, "R2 busy low", v[0], 0);
    m_pe = 5'h15;
    check_outs("R4 pe");
    rd(3'd1, v);
    chk(v == 16'h9104, "R11 addr", v, 16'h9104);

    // R3: second address write during busy ignored
    wr(3'd2, 16'h000a);
    wr(3'd1, 16'h9108);
    wr(3'd1, 16'h9104);
    rd(3'd1, v);
    chk(v == 16'h9108, "R3 addr", v, 16'h9108);
    repeat (BUSY - 2) @(negedge clk);
    rd(3'd0, v);
    chk(v[0] == 1'b0, "R3 timing", v[0], 0);
    m_le = 5'h0a;
    check_outs("R3 target");

    // R9: unmapped write and read
    wr(3'd2, 16'hbeef);
    access(16'h5104);
    check_outs("R9 write");
    read_slice(16'h5104, "R9 read");

    // R5, R6 directed
    wr(3'd2, 16'h3456); wr(3'd3, 16'h9a12);
    access(16'h1408);
    m_cc = 32'h9a123456;
    check_outs("R5 codec");
    wr(3'd2, 16'h0001); wr(3'd3, 16'h0203); wr(3'd4, 16'h0405); wr(3'd5, 16'hf607);
    access(16'h3104);
    m_tm = 64'hf607040502030001;
    check_outs("R6 timer");
    for (int i = 0; i < 4; i++) begin
      read_slice(16'h3104 | 16'(i), "R7 timer slice");
      read_slice(16'h9108 | 16'(i), "R8 narrow slice");
      read_slice(16'h1408 | 16'(i), "R8 codec slice");
    end

    // random mix
    for (int n = 0; n < 60; n++) begin
      int t;
      logic [15:0] a;
      t = $urandom_range(0, 4);
      for (int i = 0; i < 4; i++) begin
        w[i] = 16'($urandom);
        wr(3'(i + 2), w[i]);
      end
      a = base[t];
      access(a);
      case (t)
        0: m_pe = w[0][4:0];
        1: m_le = w[0][4:0];
        2: m_cc = {w[1], w[0]};
        3: m_tm = {w[3], w[2], w[1], w[0]};
        default: ;
      endcase
      check_outs(t == 2 ? "R5 rnd" : t == 3 ? "R6 rnd" : t == 4 ? "R9 rnd" : "R4 rnd");
      read_slice(base[$urandom_range(0, 4)] | 16'($urandom_range(0, 3)), "R7 rnd read");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule